// File: doc/BRIEF.md
# Pseudo-Random Memory Fill Engine

This block clears a memory by overwriting every word with pseudo-random data. A single-cycle start request loads a linear feedback shift register from the low bits of the current nonce. The engine then walks the address space from zero upward, issuing one write per clock. Each write carries the register's present value, and the register advances once per word. While the walk runs, `busy_o` is high so the surrounding logic can hold off normal memory traffic. When the last word has been written, `done_o` rises and stays high until the next start.

The walk address is kept in two counter copies. The second copy holds the bit-inverted value. Every cycle the copies are compared with each other, and the count is checked against the memory depth. A disagreement or an out-of-range count is a terminal fault. The engine stops writing in that same cycle, sets a sticky error flag and pulses a fatal alert. After that it ignores every request until reset. A parameter selects the register structure, either Galois or Fibonacci. Another parameter supplies the nonzero constant that replaces an all-zero seed.

Top module: `mli_mem_init`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o`, `alert_o` and `wr_en_o` are all 0.
- R2: A start sampled high while idle and fault-free makes the block write DEPTH words on the following DEPTH cycles, with addresses 0, 1, ..., DEPTH-1 on consecutive cycles. `wr_en_o` and `busy_o` are high on exactly those cycles.
- R3: The first word written is the seed, which is `nonce_i[DATA_W-1:0]` as sampled with start. Each later word is the register advanced once from the previous word. Galois form: `next = (s >> 1) ^ (s[0] ? POLY : 0)`. Fibonacci form: `next = {s[DATA_W-2:0], ^(s & POLY)}`.
- R4: A seed of all zeros is replaced by the parameter ZERO_SUB, so the first word written is ZERO_SUB.
- R5: `done_o` is 0 during a fill and becomes 1 in the cycle after the last write. It stays 1 until the first write of a new fill, and a new start reseeds the register.
- R6: A start request while `busy_o` is high is ignored. Addresses and data continue unchanged and the fill ends at the original time.
- R7: If the two counter copies disagree, `wr_en_o` is 0 in that same cycle. From the next cycle on, `err_o` is 1 permanently and `busy_o` and `done_o` are 0.
- R8: A counter value above DEPTH-1, with both copies agreeing, is treated the same way as in R7. This check exists only when DEPTH is not a power of two.
- R9: `alert_o` is high for exactly one cycle, the first cycle in which `err_o` is 1.
- R10: Once `err_o` is 1, start requests are ignored until reset, and no further write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Fill request, sampled each cycle |
| nonce_i | input | NONCE_W | Current nonce; low DATA_W bits seed the register |
| busy_o | output | 1 | Fill in progress; hold off normal accesses |
| done_o | output | 1 | Last fill completed |
| err_o | output | 1 | Sticky counter fault |
| alert_o | output | 1 | One-cycle fatal alert pulse |
| wr_en_o | output | 1 | Memory write enable |
| wr_addr_o | output | AW | Memory write address |
| wr_data_o | output | DATA_W | Memory write data |

## Verification
The bench builds two copies of the block side by side, and both receive the same start and nonce stimulus. The first copy uses the Galois register with a depth of 48. Because 48 is not a power of two, the out-of-range counter check is generated and can be reached by forcing both counter copies to 60. The second copy uses the Fibonacci register with a depth of 16. With that depth the range check is left out, and the copy finishes earlier, which exercises done timing against a fill that is still running. A 16-bit data width keeps the register short, so random nonces, an all-zero nonce, and stray starts in the middle of a fill all fit in a short run.

// File: rtl/mli_pkg.sv
`timescale 1ns/1ps
package mli_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FILL  = 2'd1,
      ST_FAULT = 2'd2
   } mli_state_e;

   typedef enum logic {
      LFSR_GALOIS    = 1'b0,
      LFSR_FIBONACCI = 1'b1
   } lfsr_kind_e;

endpackage

// File: rtl/mli_lfsr.sv
`timescale 1ns/1ps
module mli_lfsr #(
   parameter int                  W        = 32,
   parameter logic [W-1:0]        POLY     = 32'hB4BC_D35C,
   parameter mli_pkg::lfsr_kind_e KIND     = mli_pkg::LFSR_GALOIS,
   parameter logic [W-1:0]        ZERO_SUB = 32'h0000_0001
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic [W-1:0] seed_i,
   input  logic         step_i,
   output logic [W-1:0] state_o
);

   logic [W-1:0] state_q;
   logic [W-1:0] next_s;
   logic [W-1:0] seed_fix;

   assign seed_fix = (seed_i == '0) ? ZERO_SUB : seed_i;

   generate
      if (KIND == mli_pkg::LFSR_GALOIS) begin : g_galois
         always_comb next_s = (state_q >> 1) ^ ({W{state_q[0]}} & POLY);
      end else begin : g_fibonacci
         always_comb next_s = {state_q[W-2:0], ^(state_q & POLY)};
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ZERO_SUB;
      end else if (load_i) begin
         state_q <= seed_fix;
      end else if (step_i) begin
         state_q <= next_s;
      end
   end

   assign state_o = state_q;

endmodule

// File: rtl/mli_dual_ctr.sv
`timescale 1ns/1ps
module mli_dual_ctr #(
   parameter int DEPTH = 64,
   parameter int CW    = 6
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          clr_i,
   input  logic          inc_i,
   output logic [CW-1:0] cnt_o,
   output logic          fault_o
);

   localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

   // copy A counts up; copy B holds the bitwise complement of the same count
   logic [CW-1:0] cnt_a_q;
   logic [CW-1:0] cnt_b_q;
   logic          mismatch;
   logic          over;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_a_q <= '0;
         cnt_b_q <= '1;
      end else if (clr_i) begin
         cnt_a_q <= '0;
         cnt_b_q <= '1;
      end else if (inc_i) begin
         cnt_a_q <= cnt_a_q + 1'b1;
         cnt_b_q <= cnt_b_q - 1'b1;
      end
   end

   assign mismatch = (cnt_a_q != ~cnt_b_q);

   generate
      if (DEPTH == (1 << CW)) begin : g_full_range
         assign over = 1'b0;
      end else begin : g_range_chk
         assign over = (cnt_a_q > LAST);
      end
   endgenerate

   assign cnt_o   = cnt_a_q;
   assign fault_o = mismatch | over;

endmodule

// File: rtl/mli_seq.sv
`timescale 1ns/1ps
module mli_seq #(
   parameter int DEPTH = 64,
   parameter int CW    = 6
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          start_i,
   input  logic [CW-1:0] cnt_i,
   input  logic          fault_i,
   output logic          load_o,
   output logic          inc_o,
   output logic          step_o,
   output logic          busy_o,
   output logic          done_o,
   output logic          err_o,
   output logic          alert_o,
   output logic          wr_en_o
);

   import mli_pkg::*;

   localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

   mli_state_e state_q;
   logic       done_q;
   logic       err_q;
   logic       alert_q;
   logic       filling;
   logic       last;
   logic       accept;

   assign filling = (state_q == ST_FILL);
   assign last    = (cnt_i == LAST);
   assign accept  = (state_q == ST_IDLE) && start_i && !fault_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         alert_q <= 1'b0;
      end else begin
         alert_q <= 1'b0;
         if (fault_i && state_q != ST_FAULT) begin
            state_q <= ST_FAULT;
            err_q   <= 1'b1;
            done_q  <= 1'b0;
            alert_q <= 1'b1;
         end else begin
            unique case (state_q)
               ST_IDLE: if (accept) begin
                  state_q <= ST_FILL;
                  done_q  <= 1'b0;
               end
               ST_FILL: if (last) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end
               default: state_q <= ST_FAULT;
            endcase
         end
      end
   end

   assign load_o  = accept;
   assign inc_o   = filling && !last && !fault_i;
   assign step_o  = filling && !fault_i;
   assign busy_o  = filling;
   assign done_o  = done_q;
   assign err_o   = err_q;
   assign alert_o = alert_q;
   assign wr_en_o = filling && !fault_i;

endmodule

// File: rtl/mli_mem_init.sv
`timescale 1ns/1ps
module mli_mem_init #(
   parameter int                  DEPTH    = 1024,
   parameter int                  DATA_W   = 32,
   parameter int                  NONCE_W  = 64,
   parameter mli_pkg::lfsr_kind_e KIND     = mli_pkg::LFSR_GALOIS,
   parameter logic [DATA_W-1:0]   POLY     = 32'hB4BC_D35C,
   parameter logic [DATA_W-1:0]   ZERO_SUB = 32'h0000_0001,
   localparam int                 AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               start_i,
   input  logic [NONCE_W-1:0] nonce_i,
   output logic               busy_o,
   output logic               done_o,
   output logic               err_o,
   output logic               alert_o,
   output logic               wr_en_o,
   output logic [AW-1:0]      wr_addr_o,
   output logic [DATA_W-1:0]  wr_data_o
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (NONCE_W < DATA_W) begin : g_bad_nonce
         $error("NONCE_W must cover DATA_W");
      end
      if (ZERO_SUB == '0) begin : g_bad_sub
         $error("ZERO_SUB must be nonzero");
      end
      if (POLY == '0) begin : g_bad_poly
         $error("POLY must be nonzero");
      end
   endgenerate

   logic          load;
   logic          inc;
   logic          step;
   logic          fault;
   logic [AW-1:0] cnt;

   mli_dual_ctr #(
      .DEPTH (DEPTH),
      .CW    (AW)
   ) u_ctr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (load),
      .inc_i   (inc),
      .cnt_o   (cnt),
      .fault_o (fault)
   );

   mli_lfsr #(
      .W        (DATA_W),
      .POLY     (POLY),
      .KIND     (KIND),
      .ZERO_SUB (ZERO_SUB)
   ) u_lfsr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load),
      .seed_i  (nonce_i[DATA_W-1:0]),
      .step_i  (step),
      .state_o (wr_data_o)
   );

   mli_seq #(
      .DEPTH (DEPTH),
      .CW    (AW)
   ) u_seq (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start_i),
      .cnt_i   (cnt),
      .fault_i (fault),
      .load_o  (load),
      .inc_o   (inc),
      .step_o  (step),
      .busy_o  (busy_o),
      .done_o  (done_o),
      .err_o   (err_o),
      .alert_o (alert_o),
      .wr_en_o (wr_en_o)
   );

   assign wr_addr_o = cnt;

endmodule

// File: rtl/mli_mem_init_chk.sv
`timescale 1ns/1ps
module mli_mem_init_chk #(
   parameter int DEPTH = 1024,
   parameter int AW    = 10,
   parameter int DW    = 32
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          start_i,
   input logic          busy_o,
   input logic          done_o,
   input logic          err_o,
   input logic          alert_o,
   input logic          wr_en_o,
   input logic [AW-1:0] wr_addr_o,
   input logic [DW-1:0] wr_data_o
);

   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   p_addr_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_o && $past(wr_en_o)) |-> (wr_addr_o == AW'($past(wr_addr_o) + 1'b1)));

   p_addr_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_o |-> (wr_addr_o <= LAST));

   p_no_lockup_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_o |-> (wr_data_o != '0));

   p_done_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |-> !done_o);

   p_busy_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && start_i && wr_addr_o != LAST && !err_o) |=> (busy_o || err_o));

   p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |=> err_o);

   p_alert_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(err_o) |-> alert_o);

   p_alert_once_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alert_o |=> !alert_o);

   p_no_write_err_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |-> (!wr_en_o && !busy_o && !done_o));

endmodule

bind mli_mem_init mli_mem_init_chk #(
   .DEPTH (DEPTH),
   .AW    (AW),
   .DW    (DATA_W)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .start_i   (start_i),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .err_o     (err_o),
   .alert_o   (alert_o),
   .wr_en_o   (wr_en_o),
   .wr_addr_o (wr_addr_o),
   .wr_data_o (wr_data_o)
);

// File: tb/mli_mem_init_test.sv
`timescale 1ns/1ps
module mli_mem_init_test;

   localparam int          DW    = 16;
   localparam int          NW    = 32;
   localparam int          DG    = 48;
   localparam int          DF    = 16;
   localparam logic [15:0] POLY  = 16'hB400;
   localparam logic [15:0] ZSUB  = 16'hACE1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [NW-1:0] nonce = '0;

   logic          g_busy, g_done, g_err, g_alert, g_we;
   logic [5:0]    g_addr;
   logic [DW-1:0] g_data;
   logic          f_busy, f_done, f_err, f_alert, f_we;
   logic [3:0]    f_addr;
   logic [DW-1:0] f_data;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   mli_mem_init #(
      .DEPTH (DG), .DATA_W (DW), .NONCE_W (NW),
      .KIND (mli_pkg::LFSR_GALOIS), .POLY (POLY), .ZERO_SUB (ZSUB)
   ) uut (
      .clk_i (clk), .rst_ni (rst_n), .start_i (start), .nonce_i (nonce),
      .busy_o (g_busy), .done_o (g_done), .err_o (g_err), .alert_o (g_alert),
      .wr_en_o (g_we), .wr_addr_o (g_addr), .wr_data_o (g_data)
   );

   mli_mem_init #(
      .DEPTH (DF), .DATA_W (DW), .NONCE_W (NW),
      .KIND (mli_pkg::LFSR_FIBONACCI), .POLY (POLY), .ZERO_SUB (ZSUB)
   ) uut_fib (
      .clk_i (clk), .rst_ni (rst_n), .start_i (start), .nonce_i (nonce),
      .busy_o (f_busy), .done_o (f_done), .err_o (f_err), .alert_o (f_alert),
      .wr_en_o (f_we), .wr_addr_o (f_addr), .wr_data_o (f_data)
   );

   function automatic logic [DW-1:0] gal_next(input logic [DW-1:0] s);
      return (s >> 1) ^ ({DW{s[0]}} & POLY);
   endfunction

   function automatic logic [DW-1:0] fib_next(input logic [DW-1:0] s);
      return {s[DW-2:0], ^(s & POLY)};
   endfunction

   function automatic logic [DW-1:0] seed_of(input logic [NW-1:0] n);
      return (n[DW-1:0] == '0) ? ZSUB : n[DW-1:0];
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      start = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // full fill on both copies; stray_at >= 0 pulses start mid-fill (R6)
   task automatic do_fill(input logic [NW-1:0] n, input int stray_at);
      logic [DW-1:0] eg;
      logic [DW-1:0] ef;
      eg = seed_of(n);
      ef = seed_of(n);
      nonce = n;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      nonce = $urandom;
      for (int j = 0; j < DG; j++) begin
         chk(g_we && g_busy && !g_done && g_addr == 6'(j), "R2 galois addr/we",
             {g_we, g_busy, g_done, 7'd0, 16'd0, 2'd0, g_addr}, 32'(j));
         chk(g_data == eg, (j == 0) ? "R3/R4 galois seed word" : "R3 galois step",
             32'(g_data), 32'(eg));
         if (j < DF) begin
            chk(f_we && f_addr == 4'(j) && f_data == ef, "R3 fibonacci word",
                {f_we, 11'd0, f_addr, f_data}, {1'b1, 11'd0, 4'(j), ef});
         end else if (j == DF) begin
            chk(!f_busy && !f_we && f_done, "R5 fibonacci done",
                {f_busy, f_we, f_done}, 32'b001);
         end
         eg = gal_next(eg);
         ef = fib_next(ef);
         start = (j == stray_at);
         @(negedge clk);
      end
      start = 1'b0;
      chk(!g_busy && !g_we && g_done, "R5 galois done", {g_busy, g_we, g_done}, 32'b001);
      repeat (2) @(negedge clk);
      chk(g_done && !g_busy, "R5 done holds", {g_done, g_busy}, 32'b10);
   endtask

   initial begin : main
      void'($urandom(32'h5EED_1234));
      do_reset();
      // R1: quiet after reset
      chk({g_busy, g_done, g_err, g_alert, g_we} == 5'b0, "R1 reset galois",
          {g_busy, g_done, g_err, g_alert, g_we}, 0);
      chk({f_busy, f_done, f_err, f_alert, f_we} == 5'b0, "R1 reset fibonacci",
          {f_busy, f_done, f_err, f_alert, f_we}, 0);

      do_fill(32'h0000_1D2C, -1);
      // R4: all-zero seed replaced by the constant
      do_fill(32'hFFFF_0000, -1);
      // R6: stray starts during the fill
      do_fill(32'h0000_8001, 3);
      for (int k = 0; k < 6; k++) begin
         do_fill($urandom, (k % 2 == 0) ? int'($urandom % 14) : -1);
      end

      // R7: counter copies disagree mid-fill
      nonce = 32'h0000_BEEF;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      force uut.u_ctr.cnt_b_q = 6'd5;
      #1;
      chk(!g_we, "R7 write gated on mismatch", 32'(g_we), 0);
      @(negedge clk);
      release uut.u_ctr.cnt_b_q;
      chk(g_err && !g_busy && !g_done && !g_we, "R7 fault state",
          {g_err, g_busy, g_done, g_we}, 32'b1000);
      chk(g_alert, "R9 alert pulse", 32'(g_alert), 1);
      @(negedge clk);
      chk(!g_alert && g_err, "R9 alert single cycle", {g_alert, g_err}, 32'b01);
      // R10: start ignored once faulted
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      chk(g_err && !g_busy && !g_we, "R10 terminal", {g_err, g_busy, g_we}, 32'b100);

      // R8: both copies agree on a value past the depth
      do_reset();
      do_fill(32'h0000_0777, -1);
      force uut.u_ctr.cnt_a_q = 6'd60;
      force uut.u_ctr.cnt_b_q = 6'd3;
      @(negedge clk);
      release uut.u_ctr.cnt_a_q;
      release uut.u_ctr.cnt_b_q;
      chk(g_err && g_alert && !g_done, "R8 out-of-range fault",
          {g_err, g_alert, g_done}, 32'b110);
      chk(!f_err && f_done, "R8 fibonacci unaffected", {f_err, f_done}, 32'b01);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule